// File: doc/BRIEF.md
# SPI Banked Register and Buffer Command Slave

This block is an SPI slave (mode 0, most significant bit first) that lets a host reach a small control-register file and a byte-wide packet buffer through one-byte commands. Every frame, from the fall of chip select to its rise, carries one command. The first byte is the opcode. The bytes that follow are register data or a stream of buffer bytes. The register space has 32 addresses. The top five of them form a common group that every bank sees. The two low bits of the main control register choose which bank appears at the lower addresses. Bank 0 holds the 13-bit buffer read and write pointers.

The SPI pins are synchronised into the system clock domain, so the system clock must run at least eight times faster than the serial clock. A command state machine follows each frame. Its states are `ST_IDLE` (chip select high), `ST_OPCODE` (collecting the first byte), `ST_REG_READ`, `ST_REG_WRITE`, `ST_BUF_READ`, `ST_BUF_WRITE` and `ST_SINK` (ignoring the rest of the frame). `ST_IDLE` goes to `ST_OPCODE` when chip select is seen low. At the end of the opcode byte, `ST_OPCODE` moves to one of the four access states, or to `ST_SINK` for a soft reset or an unknown opcode. `ST_REG_WRITE` goes to `ST_SINK` after its data byte. The two buffer states stay where they are, byte after byte. Any state goes back to `ST_IDLE` when chip select rises.

Buffer storage has 2^MEM_AW bytes (2048 by default). It is addressed by the low MEM_AW bits of each 13-bit pointer, so the upper pointer range mirrors onto it.

Top module: `spi_bank_cmd_slave`

## Requirements
- R1: After rst_n, every readable register reads 0x00 (status bit 0 excepted, see R10) and spi_miso is low.
- R2: An opcode byte with bits [7:5]=000 and a 5-bit address in [4:0] returns that register's value on the next byte time.
- R3: An opcode byte with bits [7:5]=010 and a 5-bit address writes the following byte into that register. The rest of the frame is ignored.
- R4: Addresses 0x1B (interrupt enable), 0x1C (interrupt flags), 0x1D (status), 0x1E (control B) and 0x1F (control A) are seen in every bank. Control A bits [1:0] choose the bank for addresses 0x00–0x1A. Only bank 0 holds registers there: read pointer low/high at 0x00/0x01 and write pointer low/high at 0x02/0x03.
- R5: Byte 0x7A starts a buffer write. Each following complete byte is stored at the write pointer, and the pointer then advances by one if control B bit 7 is set.
- R6: Byte 0x3A starts a buffer read. Each following byte time returns the byte at the read pointer. The pointer advances by one, if control B bit 7 is set, only once a byte has been fully sent.
- R7: With control B bit 7 clear, buffer streams neither move a pointer: writes hit one location and reads repeat it.
- R8: Pointers are 13 bits wide and wrap from 0x1FFF to 0x0000. Bits [7:5] of each pointer high byte read as zero. Storage is addressed by the pointer's low MEM_AW bits.
- R9: Byte 0xFF is a soft reset. Every register and both pointers return to 0x00, and buffer contents are kept.
- R10: Status bit 0 reads 0 until READY_CYCLES clocks after rst_n and reads 1 from then on. A soft reset does not clear it, and writes to the status register are ignored.
- R11: Unused addresses read 0x00 and ignore writes. Opcodes other than those above have no effect.
- R12: A chip-select rise before a byte is complete discards that byte with no side effect.
- R13: The slave samples spi_mosi on rising spi_sclk, changes spi_miso after falling spi_sclk, and sends zeros while the opcode byte shifts in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low chip select, one command per frame |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |

## Verification
The hardest situation to reach is a pointer stepping across 0x1FFF into 0x0000 in the middle of a stream. That needs the pointer preloaded through two banked writes, with bank 0 selected. Streams must then be checked both with auto-increment on and with it off. The stimulus therefore mixes directed frames with random frames. Directed frames set up wrap-around, chip-select rises a few bits into a byte, and reads of a banked pointer from another bank. Random frames set bank, control and pointer values at random, write short bursts and read them back from the same start. Every result is compared with a register and buffer model kept in the bench.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    localparam int BYTE_W = 8;
    localparam int REG_AW = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_REG_READ,
        ST_REG_WRITE,
        ST_BUF_READ,
        ST_BUF_WRITE,
        ST_SINK
    } cmd_state_t;

    localparam logic [BYTE_W-1:0] OP_BUF_RD   = 8'h3A;
    localparam logic [BYTE_W-1:0] OP_BUF_WR   = 8'h7A;
    localparam logic [BYTE_W-1:0] OP_SOFT_RST = 8'hFF;
    localparam logic [2:0]        OPC_REG_RD  = 3'b000;
    localparam logic [2:0]        OPC_REG_WR  = 3'b010;

    localparam logic [REG_AW-1:0] A_RDPTR_LO = 5'h00;
    localparam logic [REG_AW-1:0] A_RDPTR_HI = 5'h01;
    localparam logic [REG_AW-1:0] A_WRPTR_LO = 5'h02;
    localparam logic [REG_AW-1:0] A_WRPTR_HI = 5'h03;
    localparam logic [REG_AW-1:0] A_IRQ_EN   = 5'h1B;
    localparam logic [REG_AW-1:0] A_IRQ_FLAG = 5'h1C;
    localparam logic [REG_AW-1:0] A_STATUS   = 5'h1D;
    localparam logic [REG_AW-1:0] A_CTRL_B   = 5'h1E;
    localparam logic [REG_AW-1:0] A_CTRL_A   = 5'h1F;

    localparam int AUTOINC_BIT = 7;
    localparam int READY_BIT   = 0;
    localparam int BANK_W      = 2;

endpackage

// File: rtl/sbc_spi_frontend.sv
module sbc_spi_frontend
    import sbc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              mosi,
    input  logic              tx_load,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              cs_active,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              miso
);

    localparam int CNT_W = $clog2(BYTE_W);

    logic [SYNC_STAGES:0]   sclk_pipe;
    logic [SYNC_STAGES-1:0] cs_pipe;
    logic [SYNC_STAGES-1:0] mosi_pipe;
    logic [CNT_W-1:0]       bit_cnt;
    logic [BYTE_W-2:0]      rx_sr;
    logic [BYTE_W-1:0]      tx_sr;
    logic                   miso_q;
    logic                   sclk_rise;
    logic                   sclk_fall;
    logic                   mosi_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_pipe <= '0;
            cs_pipe   <= '1;
            mosi_pipe <= '0;
        end else begin
            sclk_pipe <= {sclk_pipe[SYNC_STAGES-1:0], sclk};
            cs_pipe   <= {cs_pipe[SYNC_STAGES-2:0], cs_n};
            mosi_pipe <= {mosi_pipe[SYNC_STAGES-2:0], mosi};
        end
    end

    assign sclk_rise = sclk_pipe[SYNC_STAGES-1] & ~sclk_pipe[SYNC_STAGES];
    assign sclk_fall = ~sclk_pipe[SYNC_STAGES-1] & sclk_pipe[SYNC_STAGES];
    assign mosi_now  = mosi_pipe[SYNC_STAGES-1];
    assign cs_active = ~cs_pipe[SYNC_STAGES-1];

    // receive side: a byte completes on the eighth rising edge of the frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx_sr   <= '0;
        end else if (!cs_active) begin
            bit_cnt <= '0;
            rx_sr   <= '0;
        end else if (sclk_rise) begin
            bit_cnt <= bit_cnt + CNT_W'(1);
            rx_sr   <= {rx_sr[BYTE_W-3:0], mosi_now};
        end
    end

    assign byte_done = cs_active && sclk_rise && (bit_cnt == CNT_W'(BYTE_W - 1));
    assign rx_byte   = {rx_sr, mosi_now};

    // transmit side: the loaded byte leaves MSB first, one bit per falling edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr  <= '0;
            miso_q <= 1'b0;
        end else if (!cs_active) begin
            tx_sr  <= '0;
            miso_q <= 1'b0;
        end else if (tx_load) begin
            tx_sr  <= tx_data;
        end else if (sclk_fall) begin
            miso_q <= tx_sr[BYTE_W-1];
            tx_sr  <= {tx_sr[BYTE_W-2:0], 1'b0};
        end
    end

    assign miso = miso_q;

endmodule

// File: rtl/sbc_regfile.sv
module sbc_regfile
    import sbc_pkg::*;
#(
    parameter int PTR_W        = 13,
    parameter int READY_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [REG_AW-1:0] addr,
    input  logic              we,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              rd_adv,
    input  logic              wr_adv,
    output logic [PTR_W-1:0]  rd_ptr,
    output logic [PTR_W-1:0]  rd_ptr_step,
    output logic [PTR_W-1:0]  wr_ptr
);

    localparam int HI_W  = PTR_W - BYTE_W;
    localparam int PAD_W = BYTE_W - HI_W;
    localparam int CNT_W = $clog2(READY_CYCLES + 1);

    logic [BYTE_W-1:0] irq_en;
    logic [BYTE_W-1:0] irq_flag;
    logic [BYTE_W-1:0] ctrl_a;
    logic [BYTE_W-1:0] ctrl_b;
    logic [PTR_W-1:0]  rd_ptr_q;
    logic [PTR_W-1:0]  wr_ptr_q;
    logic [CNT_W-1:0]  ready_cnt;
    logic              ready_q;
    logic              autoinc;
    logic              bank0;

    assign autoinc = ctrl_b[AUTOINC_BIT];
    assign bank0   = (ctrl_a[BANK_W-1:0] == '0);

    // power-up ready flag, cleared only by the hardware reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ready_cnt <= '0;
            ready_q   <= 1'b0;
        end else if (ready_cnt == CNT_W'(READY_CYCLES)) begin
            ready_q   <= 1'b1;
        end else begin
            ready_cnt <= ready_cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_en   <= '0;
            irq_flag <= '0;
            ctrl_a   <= '0;
            ctrl_b   <= '0;
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
        end else if (soft_rst) begin
            irq_en   <= '0;
            irq_flag <= '0;
            ctrl_a   <= '0;
            ctrl_b   <= '0;
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
        end else if (we) begin
            unique case (addr)
                A_IRQ_EN:   irq_en   <= wdata;
                A_IRQ_FLAG: irq_flag <= wdata;
                A_CTRL_A:   ctrl_a   <= wdata;
                A_CTRL_B:   ctrl_b   <= wdata;
                A_RDPTR_LO: if (bank0) rd_ptr_q[BYTE_W-1:0]      <= wdata;
                A_RDPTR_HI: if (bank0) rd_ptr_q[PTR_W-1:BYTE_W]  <= wdata[HI_W-1:0];
                A_WRPTR_LO: if (bank0) wr_ptr_q[BYTE_W-1:0]      <= wdata;
                A_WRPTR_HI: if (bank0) wr_ptr_q[PTR_W-1:BYTE_W]  <= wdata[HI_W-1:0];
                default: ;
            endcase
        end else begin
            if (rd_adv) rd_ptr_q <= rd_ptr_step;
            if (wr_adv && autoinc) wr_ptr_q <= wr_ptr_q + PTR_W'(1);
        end
    end

    assign rd_ptr_step = autoinc ? rd_ptr_q + PTR_W'(1) : rd_ptr_q;
    assign rd_ptr      = rd_ptr_q;
    assign wr_ptr      = wr_ptr_q;

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_IRQ_EN:   rdata = irq_en;
            A_IRQ_FLAG: rdata = irq_flag;
            A_STATUS:   rdata[READY_BIT] = ready_q;
            A_CTRL_A:   rdata = ctrl_a;
            A_CTRL_B:   rdata = ctrl_b;
            A_RDPTR_LO: if (bank0) rdata = rd_ptr_q[BYTE_W-1:0];
            A_RDPTR_HI: if (bank0) rdata = {{PAD_W{1'b0}}, rd_ptr_q[PTR_W-1:BYTE_W]};
            A_WRPTR_LO: if (bank0) rdata = wr_ptr_q[BYTE_W-1:0];
            A_WRPTR_HI: if (bank0) rdata = {{PAD_W{1'b0}}, wr_ptr_q[PTR_W-1:BYTE_W]};
            default: ;
        endcase
    end

    assert_soft_reset_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (rd_ptr_q == '0 && wr_ptr_q == '0 && ctrl_a == '0 && ctrl_b == '0));

    assert_write_ptr_steps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_adv && autoinc && !we && !soft_rst) |=> (wr_ptr_q == $past(wr_ptr_q) + PTR_W'(1)));

    assert_read_ptr_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_adv && !autoinc && !we && !soft_rst) |=> $stable(rd_ptr_q));

    assert_ready_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ready_q |=> ready_q);

endmodule

// File: rtl/sbc_buffer_mem.sv
module sbc_buffer_mem
    import sbc_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [BYTE_W-1:0] rdata
);

    localparam int DEPTH = 2 ** ADDR_W;

    logic [BYTE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];

endmodule

// File: rtl/sbc_cmd_fsm.sv
module sbc_cmd_fsm
    import sbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_active,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic [REG_AW-1:0] reg_addr,
    output logic              reg_we,
    output logic              soft_rst,
    output logic              mem_we,
    output logic              rd_adv,
    output logic              wr_adv,
    output logic              tx_load,
    output logic              tx_from_mem
);

    cmd_state_t        state_q, state_d;
    logic [REG_AW-1:0] addr_q;

    // state register (with the latched register address)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_OPCODE && byte_done) addr_q <= rx_byte[REG_AW-1:0];
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!cs_active) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_OPCODE;
                ST_OPCODE: if (byte_done) begin
                    if (rx_byte == OP_BUF_RD)                     state_d = ST_BUF_READ;
                    else if (rx_byte == OP_BUF_WR)                state_d = ST_BUF_WRITE;
                    else if (rx_byte[7:5] == OPC_REG_RD)          state_d = ST_REG_READ;
                    else if (rx_byte[7:5] == OPC_REG_WR)          state_d = ST_REG_WRITE;
                    else                                          state_d = ST_SINK;
                end
                ST_REG_WRITE: if (byte_done) state_d = ST_SINK;
                ST_REG_READ, ST_BUF_READ, ST_BUF_WRITE, ST_SINK: state_d = state_q;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        reg_addr    = (state_q == ST_OPCODE) ? rx_byte[REG_AW-1:0] : addr_q;
        reg_we      = 1'b0;
        soft_rst    = 1'b0;
        mem_we      = 1'b0;
        rd_adv      = 1'b0;
        wr_adv      = 1'b0;
        tx_load     = 1'b0;
        tx_from_mem = 1'b0;
        if (byte_done) begin
            unique case (state_q)
                ST_OPCODE: begin
                    if (rx_byte == OP_SOFT_RST) begin
                        soft_rst = 1'b1;
                    end else if (rx_byte == OP_BUF_RD) begin
                        tx_load     = 1'b1;
                        tx_from_mem = 1'b1;
                    end else if (rx_byte[7:5] == OPC_REG_RD) begin
                        tx_load = 1'b1;
                    end
                end
                ST_REG_WRITE: reg_we = 1'b1;
                ST_BUF_READ: begin
                    rd_adv      = 1'b1;
                    tx_load     = 1'b1;
                    tx_from_mem = 1'b1;
                end
                ST_BUF_WRITE: begin
                    mem_we = 1'b1;
                    wr_adv = 1'b1;
                end
                default: ;
            endcase
        end
    end

    assert_idle_when_deselected_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_active |=> (state_q == ST_IDLE));

    assert_single_action_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_we, mem_we, soft_rst, tx_load}));

    assert_reg_write_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> (state_q != ST_REG_WRITE));

endmodule

// File: rtl/spi_bank_cmd_slave.sv
module spi_bank_cmd_slave
    import sbc_pkg::*;
#(
    parameter int PTR_W        = 13,
    parameter int MEM_AW       = 11,
    parameter int READY_CYCLES = 64,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sclk,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso
);

    logic              cs_active;
    logic              byte_done;
    logic [BYTE_W-1:0] rx_byte;
    logic              tx_load;
    logic              tx_from_mem;
    logic [BYTE_W-1:0] tx_data;
    logic [REG_AW-1:0] reg_addr;
    logic              reg_we;
    logic              soft_rst;
    logic              mem_we;
    logic              rd_adv;
    logic              wr_adv;
    logic [BYTE_W-1:0] reg_rdata;
    logic [BYTE_W-1:0] mem_rdata;
    logic [PTR_W-1:0]  rd_ptr;
    logic [PTR_W-1:0]  rd_ptr_step;
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  mem_rd_ptr;

    sbc_spi_frontend #(.SYNC_STAGES(SYNC_STAGES)) u_frontend (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (spi_sclk),
        .cs_n      (spi_cs_n),
        .mosi      (spi_mosi),
        .tx_load   (tx_load),
        .tx_data   (tx_data),
        .cs_active (cs_active),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .miso      (spi_miso)
    );

    sbc_cmd_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_active   (cs_active),
        .byte_done   (byte_done),
        .rx_byte     (rx_byte),
        .reg_addr    (reg_addr),
        .reg_we      (reg_we),
        .soft_rst    (soft_rst),
        .mem_we      (mem_we),
        .rd_adv      (rd_adv),
        .wr_adv      (wr_adv),
        .tx_load     (tx_load),
        .tx_from_mem (tx_from_mem)
    );

    sbc_regfile #(.PTR_W(PTR_W), .READY_CYCLES(READY_CYCLES)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst    (soft_rst),
        .addr        (reg_addr),
        .we          (reg_we),
        .wdata       (rx_byte),
        .rdata       (reg_rdata),
        .rd_adv      (rd_adv),
        .wr_adv      (wr_adv),
        .rd_ptr      (rd_ptr),
        .rd_ptr_step (rd_ptr_step),
        .wr_ptr      (wr_ptr)
    );

    // a read stream fetches the byte the pointer is about to reach
    assign mem_rd_ptr = rd_adv ? rd_ptr_step : rd_ptr;

    sbc_buffer_mem #(.ADDR_W(MEM_AW)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (wr_ptr[MEM_AW-1:0]),
        .wdata (rx_byte),
        .raddr (mem_rd_ptr[MEM_AW-1:0]),
        .rdata (mem_rdata)
    );

    generate
        if (MEM_AW < PTR_W) begin : g_mirror
            logic unused_ptr_hi;
            assign unused_ptr_hi = ^{wr_ptr[PTR_W-1:MEM_AW], mem_rd_ptr[PTR_W-1:MEM_AW]};
        end
    endgenerate

    assign tx_data = tx_from_mem ? mem_rdata : reg_rdata;

    assert_action_inside_frame_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we || mem_we || soft_rst) |-> cs_active);

    assert_miso_quiet_deselected_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_active && $past(!cs_active)) |-> !spi_miso);

endmodule

// File: tb/test_spi_bank_cmd_slave.sv
`timescale 1ns/1ps
module test_spi_bank_cmd_slave;

    localparam int HALF    = 8;
    localparam int MEM_AW  = 11;
    localparam int MEM_N   = 2 ** MEM_AW;
    localparam int RDY     = 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    spi_bank_cmd_slave #(.READY_CYCLES(RDY)) i_spi_bank_cmd_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_sclk (sclk),
        .spi_cs_n (cs_n),
        .spi_mosi (mosi),
        .spi_miso (miso)
    );

    // bench model
    logic [7:0]  m_ie, m_if, m_ca, m_cb;
    logic [12:0] m_rdp, m_wrp;
    logic        m_ready;
    logic [7:0]  m_mem [MEM_N];
    bit          m_ok  [MEM_N];

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_reg(input logic [4:0] a);
        logic b0;
        b0 = (m_ca[1:0] == 2'b00);
        case (a)
            5'h1B: return m_ie;
            5'h1C: return m_if;
            5'h1D: return {7'b0, m_ready};
            5'h1E: return m_cb;
            5'h1F: return m_ca;
            5'h00: return b0 ? m_rdp[7:0] : 8'h00;
            5'h01: return b0 ? {3'b000, m_rdp[12:8]} : 8'h00;
            5'h02: return b0 ? m_wrp[7:0] : 8'h00;
            5'h03: return b0 ? {3'b000, m_wrp[12:8]} : 8'h00;
            default: return 8'h00;
        endcase
    endfunction

    function automatic void mdl_write(input logic [4:0] a, input logic [7:0] d);
        logic b0;
        b0 = (m_ca[1:0] == 2'b00);
        case (a)
            5'h1B: m_ie = d;
            5'h1C: m_if = d;
            5'h1E: m_cb = d;
            5'h1F: m_ca = d;
            5'h00: if (b0) m_rdp[7:0]  = d;
            5'h01: if (b0) m_rdp[12:8] = d[4:0];
            5'h02: if (b0) m_wrp[7:0]  = d;
            5'h03: if (b0) m_wrp[12:8] = d[4:0];
            default: ;
        endcase
    endfunction

    function automatic void mdl_soft_reset();
        m_ie = 0; m_if = 0; m_ca = 0; m_cb = 0; m_rdp = 0; m_wrp = 0;
    endfunction

    // SPI mode 0 master
    task automatic xfer_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i > 7 - nbits; i--) begin
            mosi = tx[i];
            wait_clks(HALF);
            rx[i] = miso;
            sclk = 1'b1;
            wait_clks(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        xfer_bits(tx, 8, rx);
    endtask

    task automatic cs_begin();
        cs_n = 1'b0;
        wait_clks(4);
    endtask

    task automatic cs_end();
        wait_clks(4);
        cs_n = 1'b1;
        wait_clks(6);
    endtask

    task automatic reg_wr(input logic [4:0] a, input logic [7:0] d);
        logic [7:0] rx;
        cs_begin();
        xfer({3'b010, a}, rx);
        xfer(d, rx);
        cs_end();
        mdl_write(a, d);
    endtask

    task automatic reg_rd(input logic [4:0] a, output logic [7:0] d, output logic [7:0] first);
        cs_begin();
        xfer({3'b000, a}, first);
        xfer(8'h00, d);
        cs_end();
    endtask

    task automatic reg_chk(input logic [4:0] a, input string tag);
        logic [7:0] d, first;
        reg_rd(a, d, first);
        chk({8'h0, d}, {8'h0, exp_reg(a)}, tag);
    endtask

    task automatic set_ptrs(input logic [12:0] rp, input logic [12:0] wp);
        reg_wr(5'h1F, {m_ca[7:2], 2'b00});
        reg_wr(5'h00, rp[7:0]);
        reg_wr(5'h01, {3'b000, rp[12:8]});
        reg_wr(5'h02, wp[7:0]);
        reg_wr(5'h03, {3'b000, wp[12:8]});
    endtask

    task automatic buf_wr(input int n, input logic [7:0] first, input logic [7:0] step);
        logic [7:0] rx, d;
        cs_begin();
        xfer(8'h7A, rx);
        for (int i = 0; i < n; i++) begin
            d = first + 8'(i) * step;
            xfer(d, rx);
            m_mem[m_wrp[MEM_AW-1:0]] = d;
            m_ok[m_wrp[MEM_AW-1:0]]  = 1'b1;
            if (m_cb[7]) m_wrp = m_wrp + 13'd1;
        end
        cs_end();
    endtask

    task automatic buf_rd(input int n, input string tag);
        logic [7:0] rx;
        cs_begin();
        xfer(8'h3A, rx);
        for (int i = 0; i < n; i++) begin
            xfer(8'h00, rx);
            if (m_ok[m_rdp[MEM_AW-1:0]])
                chk({8'h0, rx}, {8'h0, m_mem[m_rdp[MEM_AW-1:0]]}, tag);
            if (m_cb[7]) m_rdp = m_rdp + 13'd1;
        end
        cs_end();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, first, rx;
        void'($urandom(32'h5EED_0042));
        mdl_soft_reset();
        m_ready = 1'b0;
        for (int i = 0; i < MEM_N; i++) m_ok[i] = 1'b0;
        wait_clks(5);
        rst_n = 1'b1;
        wait_clks(3);

        // R1 / R10: reset state, status not ready yet
        chk({15'h0, miso}, 16'h0, "R1 miso idle after reset");
        reg_rd(5'h1D, d, first);
        chk({8'h0, d}, 16'h0, "R10 status not ready early");
        chk({8'h0, first}, 16'h0, "R13 zeros during opcode byte");
        reg_chk(5'h1F, "R1 control A reset");
        reg_chk(5'h1E, "R1 control B reset");
        reg_chk(5'h1B, "R1 irq enable reset");
        reg_chk(5'h00, "R1 read ptr low reset");
        reg_chk(5'h03, "R1 write ptr high reset");
        wait_clks(RDY);
        m_ready = 1'b1;
        reg_chk(5'h1D, "R10 status ready");
        reg_wr(5'h1D, 8'hFE);
        reg_chk(5'h1D, "R10 status write ignored");

        // R2 / R3: common registers
        reg_wr(5'h1B, 8'hA5);
        reg_chk(5'h1B, "R2 R3 irq enable write/read");
        reg_wr(5'h1C, 8'h3C);
        reg_chk(5'h1C, "R2 R3 irq flag write/read");

        // R4 / R11: banking
        set_ptrs(13'h0123, 13'h0456);
        reg_wr(5'h1F, 8'h02);
        reg_chk(5'h1B, "R4 common reg seen in bank 2");
        reg_chk(5'h00, "R4 pointer hidden in bank 2");
        reg_wr(5'h00, 8'h77);
        reg_wr(5'h05, 8'h99);
        reg_chk(5'h05, "R11 unused address reads zero");
        reg_wr(5'h1F, 8'h00);
        reg_chk(5'h00, "R4 R11 bank-2 write left read ptr");
        reg_chk(5'h01, "R4 read ptr high in bank 0");

        // R8: high byte upper bits
        reg_wr(5'h01, 8'hFF);
        reg_chk(5'h01, "R8 high byte upper bits zero");

        // R5 / R6 / R8: wrap with auto-increment
        reg_wr(5'h1E, 8'h80);
        set_ptrs(13'h1FFF, 13'h1FFF);
        buf_wr(3, 8'h10, 8'h11);
        reg_chk(5'h02, "R8 write ptr wrapped low");
        reg_chk(5'h03, "R8 write ptr wrapped high");
        buf_rd(3, "R6 stream read across wrap");
        reg_chk(5'h00, "R6 read ptr after 3 bytes");

        // R7: no auto-increment
        reg_wr(5'h1E, 8'h00);
        set_ptrs(13'h0040, 13'h0040);
        buf_wr(3, 8'hC1, 8'h01);
        reg_chk(5'h02, "R7 write ptr held");
        buf_rd(2, "R7 repeated read");
        reg_chk(5'h00, "R7 read ptr held");

        // R11: unknown opcode
        reg_wr(5'h1F, 8'h00);
        cs_begin(); xfer(8'h9F, rx); xfer(8'h03, rx); cs_end();
        reg_chk(5'h1F, "R11 unknown opcode no effect");

        // R12: aborted bytes
        cs_begin(); xfer(8'h5F, rx); xfer_bits(8'h03, 5, rx); cs_end();
        reg_chk(5'h1F, "R12 partial register data dropped");
        reg_wr(5'h1E, 8'h80);
        set_ptrs(13'h0200, 13'h0200);
        cs_begin(); xfer(8'h7A, rx); xfer(8'h5A, rx); xfer_bits(8'hFF, 3, rx); cs_end();
        m_mem[m_wrp[MEM_AW-1:0]] = 8'h5A; m_ok[m_wrp[MEM_AW-1:0]] = 1'b1; m_wrp = m_wrp + 13'd1;
        reg_chk(5'h02, "R12 write ptr after partial byte");
        buf_rd(2, "R12 R5 buffer after abort");

        // R9: soft reset keeps memory
        reg_wr(5'h1B, 8'h5C);
        cs_begin(); xfer(8'hFF, rx); cs_end();
        mdl_soft_reset();
        reg_chk(5'h1B, "R9 irq enable cleared");
        reg_chk(5'h02, "R9 write ptr cleared");
        reg_chk(5'h1D, "R9 R10 ready survives soft reset");
        reg_wr(5'h1E, 8'h80);
        set_ptrs(13'h1FFF, 13'h0000);
        buf_rd(2, "R9 buffer kept after soft reset");

        // random mix
        for (int it = 0; it < 110; it++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op <= 2) begin
                logic [4:0] a;
                a = (op == 0) ? 5'($urandom_range(27, 31)) : 5'($urandom_range(0, 7));
                reg_wr(a, 8'($urandom));
            end else if (op <= 5) begin
                reg_chk(5'($urandom_range(0, 31)), "R2 R4 random register read");
            end else if (op <= 8) begin
                logic [12:0] p;
                int n;
                p = 13'($urandom);
                n = $urandom_range(1, 4);
                reg_wr(5'h1E, {$urandom_range(0, 1) == 1 ? 1'b1 : 1'b0, 7'($urandom)});
                set_ptrs(p, p);
                buf_wr(n, 8'($urandom), 8'($urandom));
                buf_rd(n, "R5 R6 random stream");
                reg_chk(5'h02, "R5 random write ptr");
                reg_chk(5'h00, "R6 random read ptr");
            end else begin
                cs_begin(); xfer(8'hFF, rx); cs_end();
                mdl_soft_reset();
                reg_chk(5'h1F, "R9 random soft reset");
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule